// File: doc/BRIEF.md
# Long-Run Zero-Data Detector

This block watches a stream of received stereo sample frames and raises a zero-detect flag. The flag tells downstream logic that no audio content is present. It covers two situations. The first is the span after reset, before processing has locked onto the frame clock and finished a short start-up interval. The second is a long unbroken run of digital silence on both channels.

After reset, the block waits for a rising edge of the sample-rate reference. On that edge it emits a one-cycle start-of-operation pulse. It then lets a fixed number of frames pass as a start-up interval, and only after that begins counting silent frames. The count is updated once for each frame strobe. When the count reaches the run length, the flag rises. The first frame that carries a non-zero sample drops the flag again.

Top module: `zero_run_detector`

## Requirements
- R1: While `rst_n` is low, `zero_flag` is 1 and `op_start` is 0.
- R2: `op_start` is high for exactly one clock, in the cycle where `frame_clk` is sampled high after having been low, and only for the first such rising edge after reset. A `frame_clk` level that is already high when reset is released is not an edge. Later rising edges never pulse `op_start`.
- R3: `zero_flag` stays 1 from reset through the wait for alignment and through the first INIT_FRAMES (8) frame strobes after the alignment edge. Strobes that arrive before the alignment edge are not counted.
- R4: `zero_flag` falls in the clock cycle after the INIT_FRAMES-th start-up strobe. Sample values seen during start-up have no effect on the silence count, which starts at zero.
- R5: A frame counts as silent only when both `left_smp` and `right_smp` are exactly zero. A single non-zero channel makes the frame non-silent.
- R6: After start-up, `zero_flag` rises in the cycle after the RUN_LEN-th (16384) consecutive silent frame strobe, and not earlier.
- R7: A non-zero frame strobe drops `zero_flag` in the next cycle and restarts the run, so RUN_LEN further silent frames are needed to raise it again.
- R8: Sample values present while `frame_vld` is low do not affect the silence count.
- R9: The silence count saturates. Silent frames beyond RUN_LEN keep `zero_flag` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Sample-rate reference, synchronous to `clk` |
| frame_vld | input | 1 | One-cycle strobe marking a received frame |
| left_smp | input | SAMPLE_W | Left-channel sample, two's complement |
| right_smp | input | SAMPLE_W | Right-channel sample, two's complement |
| zero_flag | output | 1 | High during start-up or after a long silent run |
| op_start | output | 1 | One-cycle pulse on the alignment edge |

## Verification
The bench drives the run exactly to its boundary. It checks that the flag stays low through frame 16383 and rises right after frame 16384. A counter that is off by one would raise the flag one frame early or one frame late.

Several cases feed only one zero channel. A detector that tested only one channel would then treat a half-silent frame as silent. The bench also places non-zero data while `frame_vld` is low in the middle of a run. A detector that ignored the strobe would restart the run, and the flag would come late.

The flag is raised, then cleared by a single non-zero frame, and the full run is measured again. A detector that cleared the flag but kept its count would raise the flag again far too soon.

The bench checks that a `frame_clk` that is already high at reset release does not count as the alignment edge, and that rising edges after alignment produce no second pulse. It also checks that strobes before alignment do not shorten the start-up interval. A design that got any of these wrong would end start-up early or realign in the middle of operation.

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
  parameter int SAMPLE_W    = 16,
  parameter int RUN_LEN     = 16384,
  parameter int INIT_FRAMES = 8,
  localparam int CNT_W      = $clog2(RUN_LEN + 1),
  localparam int INIT_W     = $clog2(INIT_FRAMES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_clk,
  input  logic                frame_vld,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  output logic                zero_flag,
  output logic                op_start
);

  typedef enum logic [1:0] {S_ALIGN, S_INIT, S_RUN} phase_t;

  phase_t            phase;
  logic              fc_q;
  logic [INIT_W-1:0] init_cnt;
  logic [CNT_W-1:0]  run_cnt;

  logic fc_rise, frame_zero, init_last, run_full;

  assign fc_rise    = frame_clk & ~fc_q;
  assign frame_zero = (left_smp == '0) && (right_smp == '0);
  assign init_last  = (init_cnt == INIT_W'(INIT_FRAMES - 1));
  assign run_full   = (run_cnt == CNT_W'(RUN_LEN));
  assign op_start   = (phase == S_ALIGN) & fc_rise;
  assign zero_flag  = (phase != S_RUN) | run_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q     <= 1'b1;
      phase    <= S_ALIGN;
      init_cnt <= '0;
      run_cnt  <= '0;
    end else begin
      fc_q <= frame_clk;
      case (phase)
        S_ALIGN: if (fc_rise) begin
          phase    <= S_INIT;
          init_cnt <= '0;
        end
        S_INIT: if (frame_vld) begin
          if (init_last) begin
            phase   <= S_RUN;
            run_cnt <= '0;
          end else begin
            init_cnt <= init_cnt + 1'b1;
          end
        end
        default: if (frame_vld) begin
          if (!frame_zero)   run_cnt <= '0;
          else if (!run_full) run_cnt <= run_cnt + 1'b1;
        end
      endcase
    end
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  // R3
  start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> zero_flag);

  // R7
  nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_RUN && frame_vld && !frame_zero) |=> !zero_flag);

  // R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(zero_flag) && $past(phase) == S_RUN) |-> $past(frame_vld && frame_zero));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(RUN_LEN));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_RUN && !frame_vld) |=> $stable(run_cnt));

endmodule

// File: tb/test_zero_run_detector.sv
module test_zero_run_detector;
  localparam int SW = 16;
  localparam int RUN = 16384;
  localparam int INITF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b1;
  logic frame_vld = 1'b0;
  logic [SW-1:0] left_smp = '0;
  logic [SW-1:0] right_smp = '0;
  logic zero_flag, op_start;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct { logic exp; string tag; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  zero_run_detector #(.SAMPLE_W(SW), .RUN_LEN(RUN), .INIT_FRAMES(INITF)) i_zero_run_detector (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .frame_vld(frame_vld),
    .left_smp(left_smp), .right_smp(right_smp),
    .zero_flag(zero_flag), .op_start(op_start));

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r,
                      input logic exp, input string tag);
    item_t it;
    left_smp = l; right_smp = r; frame_vld = 1'b1;
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    frame_vld = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rst_n && frame_vld) begin
      item_t it;
      #2;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=strobe expected=no strobe");
      end else begin
        it = exp_q.pop_front();
        check(zero_flag, it.exp, it.tag);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(zero_flag, 1'b1, "R1 flag in reset");
    check(op_start, 1'b0, "R1 start in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check(op_start, 1'b0, "R2 high level at release is no edge");
    check(zero_flag, 1'b1, "R3 flag before alignment");
    @(negedge clk);
    for (int i = 0; i < 3; i++) send(16'h1234, 16'h0042, 1'b1, "R3 pre-align strobe");
    frame_clk = 1'b0;
    @(negedge clk);
    frame_clk = 1'b1;
    #1 check(op_start, 1'b1, "R2 pulse on first rise");
    @(posedge clk); #1;
    check(op_start, 1'b0, "R2 pulse one cycle");
    @(negedge clk);
    for (int i = 0; i < INITF - 1; i++) begin
      send(16'h0000, 16'h0000, 1'b1, "R3 start-up frame");
      if (i == 2) begin
        frame_clk = 1'b0; @(negedge clk);
        frame_clk = 1'b1; #1 check(op_start, 1'b0, "R2 no pulse during start-up");
        @(negedge clk);
      end
    end
    send(16'h0000, 16'h0000, 1'b0, "R4 start-up ends");
    send(16'h0000, 16'h0005, 1'b0, "R5 right non-zero");
    send(16'h0005, 16'h0000, 1'b0, "R5 left non-zero");
    send(16'h0001, 16'h0001, 1'b0, "R5 both non-zero");
    for (int i = 0; i < RUN - 1; i++) begin
      send(16'h0000, 16'h0000, 1'b0, "R6 below run length");
      if (i == 100) begin
        left_smp = 16'h7fff; right_smp = 16'h8000;
        repeat (4) @(negedge clk);
        left_smp = '0; right_smp = '0;
        check(zero_flag, 1'b0, "R8 flag with unstrobed data");
      end
    end
    send(16'h0000, 16'h0000, 1'b1, "R6 run length reached");
    frame_clk = 1'b0; @(negedge clk);
    frame_clk = 1'b1; #1 check(op_start, 1'b0, "R2 no pulse in operation");
    @(negedge clk);
    for (int i = 0; i < 3; i++) send(16'h0000, 16'h0000, 1'b1, "R9 saturated run");
    send(16'h8000, 16'h0000, 1'b0, "R7 non-zero clears flag");
    for (int i = 0; i < RUN - 1; i++) send(16'h0000, 16'h0000, 1'b0, "R7 restarted run");
    send(16'h0000, 16'h0000, 1'b1, "R7 full run after restart");
    send(16'h0000, 16'hffff, 1'b0, "R7 clear again");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, 1'b1, "R6 scoreboard drained");
    summary();
  end
endmodule